// File: doc/BRIEF.md
# Call and Interrupt Stack Sequencer

This block owns the 8-bit stack pointer of a small 8-bit processor. It turns one command into the byte-wide memory transfers that save or restore the program counter and status byte. Five commands exist: subroutine call, subroutine return, hardware interrupt entry, break entry and interrupt return. The stack lives in one 256-byte page. A page select bit chooses page 0x00 or page 0x01 for the high address byte, and the pointer supplies the low byte.

A command is accepted in an idle cycle. The block then makes exactly one memory access per clock and holds `busy` high until the sequence ends. Pushes write at the current pointer and then move it down. Pops move the pointer up and read at the new position. When an entry sequence finishes its pushes, the block pulses a request to set the interrupt-disable flag and then pulses a vector-fetch request. When a pop sequence finishes, it pulses load strobes together with the rebuilt program counter and, after an interrupt return, the rebuilt status byte. Software loads the pointer through a load port while the block is idle.

Top module: `callstack_seq`

## Requirements
- R1: Every stack access uses address {7'b0, page, pointer-derived low byte}, where `page` is the page select bit latched when the command is accepted. The high byte is therefore 0x00 or 0x01.
- R2: A call (cmd = 3'd1) writes PC[15:8] at the current pointer and then PC[7:0] at pointer-1. The pointer drops by one after each write, and `busy` stays high for exactly 2 cycles.
- R3: An interrupt entry (cmd = 3'd3) writes PC[15:8], then PC[7:0], then the status byte with bit 4 forced to 0, at descending addresses. The pointer drops by 3 in total.
- R4: After the three entry writes of an interrupt or break, `set_idis` is high for one cycle and `vec_req` is high for one cycle in the cycle after it. `busy` covers 5 cycles and falls after the `vec_req` cycle. Other commands raise neither signal.
- R5: A return (cmd = 3'd2) reads PC[7:0] at pointer+1 and then PC[15:8] at pointer+2, raising the pointer by one per read. In the following cycle, `pc_load` is high with `pc_out` holding the rebuilt PC, and `busy` lasts 3 cycles.
- R6: An interrupt return (cmd = 3'd5) reads the status byte, then PC[7:0], then PC[15:8] at ascending addresses. The pointer rises by 3. In the next cycle, `pc_load` and `status_load` are high together, and `busy` lasts 4 cycles.
- R7: An interrupt command issued while `irq_dis` = 1 is dropped: `busy` stays low, no memory access occurs and the pointer is unchanged. A break is accepted whatever the value of `irq_dis`.
- R8: A break (cmd = 3'd4) writes the same three bytes as an interrupt entry, except that the pushed status byte has bit 4 set to 1. The status byte delivered on `status_out` after an interrupt return always has bit 4 cleared.
- R9: The pointer wraps modulo 256 inside the selected page in both directions, with no overflow indication.
- R10: After reset the block is idle, with `busy`, `mem_we`, `mem_re`, `set_idis` and `vec_req` all low. A pointer load applies only while idle. Commands and pointer loads issued while `busy` is high are ignored, and at most one of `mem_we` and `mem_re` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, sampled while idle |
| cmd | input | 3 | 1 call, 2 return, 3 interrupt, 4 break, 5 interrupt return, others none |
| irq_dis | input | 1 | Interrupt-disable flag from the status register |
| pc_in | input | 16 | Program counter to be pushed |
| status_in | input | 8 | Live status byte to be pushed |
| page_sel | input | 1 | Stack page select: 0 gives page 0x00, 1 gives page 0x01 |
| sp_load | input | 1 | Load the pointer from `sp_load_val` (idle only) |
| sp_load_val | input | 8 | Pointer value to load |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_re` |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| busy | output | 1 | Sequence in progress |
| sp | output | 8 | Current stack pointer |
| pc_out | output | 16 | Program counter rebuilt from the stack |
| pc_load | output | 1 | One-cycle strobe: load `pc_out` |
| status_out | output | 8 | Status byte rebuilt from the stack, bit 4 cleared |
| status_load | output | 1 | One-cycle strobe: load `status_out` |
| set_idis | output | 1 | One-cycle request to set the interrupt-disable flag |
| vec_req | output | 1 | One-cycle jump-vector fetch request |

## Verification
The bench drives the pointer across the 0x00/0xFF boundary in both directions. A design that wrapped incorrectly would leave the page or write to a neighbouring page. It checks the pop direction too: pointer+1 first, low byte before high. A design that read before incrementing, or swapped the bytes, would return a byte-swapped or shifted PC. It compares the break and interrupt status copies, pushed with bit 4 set and cleared respectively, and it issues a masked interrupt, which must leave the memory untouched. It also fires a command and a pointer load in the middle of a call, where a design that accepted them would corrupt the pointer or start an extra read.

// File: rtl/cstk_pkg.sv
package cstk_pkg;

    localparam int BYTE_W   = 8;
    localparam int PC_W     = 16;
    localparam int ADDR_W   = 16;
    localparam int PAGE_PAD = ADDR_W - BYTE_W - 1;
    localparam int BRK_POS  = 4;
    localparam int MAX_XFER = 3;
    localparam int IDX_W    = $clog2(MAX_XFER);

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_CALL = 3'd1,
        OP_RET  = 3'd2,
        OP_IRQ  = 3'd3,
        OP_BRK  = 3'd4,
        OP_RTI  = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_XFER,
        PH_SETI,
        PH_VEC,
        PH_LOAD
    } phase_e;

    typedef enum logic [1:0] {
        SRC_PCH,
        SRC_PCL,
        SRC_ST,
        SRC_NONE
    } src_e;

    typedef struct packed {
        logic wr;
        logic rd;
        src_e src;
    } step_t;

    // index of the final transfer of a command
    function automatic logic [IDX_W-1:0] last_idx(op_e op);
        case (op)
            OP_CALL, OP_RET: last_idx = IDX_W'(1);
            default:         last_idx = IDX_W'(MAX_XFER - 1);
        endcase
    endfunction

    // which byte moves, and in which direction, at transfer idx
    function automatic step_t step_plan(op_e op, logic [IDX_W-1:0] idx);
        step_t s;
        s.wr  = 1'b0;
        s.rd  = 1'b0;
        s.src = SRC_NONE;
        case (op)
            OP_CALL: begin
                s.wr  = 1'b1;
                s.src = (idx == '0) ? SRC_PCH : SRC_PCL;
            end
            OP_RET: begin
                s.rd  = 1'b1;
                s.src = (idx == '0) ? SRC_PCL : SRC_PCH;
            end
            OP_IRQ, OP_BRK: begin
                s.wr  = 1'b1;
                s.src = (idx == '0) ? SRC_PCH :
                        (idx == IDX_W'(1)) ? SRC_PCL : SRC_ST;
            end
            OP_RTI: begin
                s.rd  = 1'b1;
                s.src = (idx == '0) ? SRC_ST :
                        (idx == IDX_W'(1)) ? SRC_PCL : SRC_PCH;
            end
            default: ;
        endcase
        return s;
    endfunction

    function automatic logic accept_ok(op_e op, logic idis);
        case (op)
            OP_CALL, OP_RET, OP_BRK, OP_RTI: accept_ok = 1'b1;
            OP_IRQ:                          accept_ok = ~idis;
            default:                         accept_ok = 1'b0;
        endcase
    endfunction

    // status copy placed on the stack: break marker only for breaks
    function automatic logic [BYTE_W-1:0] push_status(op_e op, logic [BYTE_W-1:0] st);
        logic [BYTE_W-1:0] r;
        r = st;
        r[BRK_POS] = (op == OP_BRK);
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] stack_addr(logic page, logic [BYTE_W-1:0] lo);
        return {{PAGE_PAD{1'b0}}, page, lo};
    endfunction

endpackage

// File: rtl/cstk_ptr.sv
module cstk_ptr
    import cstk_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] sp,
    output logic [W-1:0] sp_up
);

    localparam logic [W-1:0] ONE = W'(1);

    // left unreset: software loads the pointer before use
    always_ff @(posedge clk) begin
        if (ld)
            sp <= ld_val;
        else if (inc)
            sp <= sp + ONE;
        else if (dec)
            sp <= sp - ONE;
    end

    assign sp_up = sp + ONE;

endmodule

// File: rtl/cstk_ctrl.sv
module cstk_ctrl
    import cstk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd,
    input  logic              irq_dis,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [BYTE_W-1:0] status_in,
    input  logic              page_sel,
    output step_t             step,
    output logic [PC_W-1:0]   pc_q,
    output logic [BYTE_W-1:0] st_q,
    output logic              page_q,
    output logic              busy,
    output logic              set_idis,
    output logic              vec_req,
    output logic              pc_load,
    output logic              status_load
);

    phase_e           phase_q;
    op_e              op_q;
    logic [IDX_W-1:0] idx_q;
    op_e              op_in;
    logic             entry_op;
    logic             pop_op;

    assign op_in    = op_e'(cmd);
    assign entry_op = (op_q == OP_IRQ) || (op_q == OP_BRK);
    assign pop_op   = (op_q == OP_RET) || (op_q == OP_RTI);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            op_q    <= OP_NONE;
            idx_q   <= '0;
            pc_q    <= '0;
            st_q    <= '0;
            page_q  <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (cmd_valid && accept_ok(op_in, irq_dis)) begin
                        phase_q <= PH_XFER;
                        op_q    <= op_in;
                        idx_q   <= '0;
                        pc_q    <= pc_in;
                        st_q    <= push_status(op_in, status_in);
                        page_q  <= page_sel;
                    end
                end
                PH_XFER: begin
                    if (idx_q == last_idx(op_q)) begin
                        idx_q <= '0;
                        if (entry_op)
                            phase_q <= PH_SETI;
                        else if (pop_op)
                            phase_q <= PH_LOAD;
                        else
                            phase_q <= PH_IDLE;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                PH_SETI: phase_q <= PH_VEC;
                PH_VEC:  phase_q <= PH_IDLE;
                PH_LOAD: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        step = step_plan(op_q, idx_q);
        if (phase_q != PH_XFER) begin
            step.wr  = 1'b0;
            step.rd  = 1'b0;
            step.src = SRC_NONE;
        end
    end

    assign busy        = (phase_q != PH_IDLE);
    assign set_idis    = (phase_q == PH_SETI);
    assign vec_req     = (phase_q == PH_VEC);
    assign pc_load     = (phase_q == PH_LOAD);
    assign status_load = (phase_q == PH_LOAD) && (op_q == OP_RTI);

endmodule

// File: rtl/cstk_restore.sv
module cstk_restore
    import cstk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  src_e              src,
    input  logic [BYTE_W-1:0] rdata,
    output logic [PC_W-1:0]   pc_out,
    output logic [BYTE_W-1:0] status_out
);

    logic [BYTE_W-1:0] pch_r;
    logic [BYTE_W-1:0] pcl_r;
    logic [BYTE_W-1:0] st_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            pch_r <= '0;
            pcl_r <= '0;
            st_r  <= '0;
        end else if (capture) begin
            case (src)
                SRC_PCH: pch_r <= rdata;
                SRC_PCL: pcl_r <= rdata;
                SRC_ST:  st_r  <= rdata;
                default: ;
            endcase
        end
    end

    // the live status never holds the break marker
    always_comb begin
        status_out          = st_r;
        status_out[BRK_POS] = 1'b0;
    end

    assign pc_out = {pch_r, pcl_r};

endmodule

// File: rtl/callstack_seq.sv
module callstack_seq
    import cstk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd,
    input  logic              irq_dis,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [BYTE_W-1:0] status_in,
    input  logic              page_sel,
    input  logic              sp_load,
    input  logic [BYTE_W-1:0] sp_load_val,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic              busy,
    output logic [BYTE_W-1:0] sp,
    output logic [PC_W-1:0]   pc_out,
    output logic              pc_load,
    output logic [BYTE_W-1:0] status_out,
    output logic              status_load,
    output logic              set_idis,
    output logic              vec_req
);

    step_t             step;
    logic [PC_W-1:0]   pc_q;
    logic [BYTE_W-1:0] st_q;
    logic              page_q;
    logic [BYTE_W-1:0] sp_up;
    logic [BYTE_W-1:0] addr_lo;

    cstk_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd         (cmd),
        .irq_dis     (irq_dis),
        .pc_in       (pc_in),
        .status_in   (status_in),
        .page_sel    (page_sel),
        .step        (step),
        .pc_q        (pc_q),
        .st_q        (st_q),
        .page_q      (page_q),
        .busy        (busy),
        .set_idis    (set_idis),
        .vec_req     (vec_req),
        .pc_load     (pc_load),
        .status_load (status_load)
    );

    cstk_ptr #(.W(BYTE_W)) u_ptr (
        .clk    (clk),
        .ld     (sp_load && !busy),
        .ld_val (sp_load_val),
        .inc    (step.rd),
        .dec    (step.wr),
        .sp     (sp),
        .sp_up  (sp_up)
    );

    cstk_restore u_restore (
        .clk        (clk),
        .rst        (rst),
        .capture    (step.rd),
        .src        (step.src),
        .rdata      (mem_rdata),
        .pc_out     (pc_out),
        .status_out (status_out)
    );

    // pops pre-increment, pushes post-decrement
    assign addr_lo  = step.rd ? sp_up : sp;
    assign mem_addr = stack_addr(page_q, addr_lo);
    assign mem_we   = step.wr;
    assign mem_re   = step.rd;

    always_comb begin
        case (step.src)
            SRC_PCH: mem_wdata = pc_q[PC_W-1:BYTE_W];
            SRC_PCL: mem_wdata = pc_q[BYTE_W-1:0];
            SRC_ST:  mem_wdata = st_q;
            default: mem_wdata = '0;
        endcase
    end

endmodule

// File: rtl/callstack_seq_chk.sv
module callstack_seq_chk
    import cstk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [2:0]        cmd,
    input logic              irq_dis,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_re,
    input logic              busy,
    input logic [BYTE_W-1:0] sp,
    input logic              pc_load,
    input logic              status_load,
    input logic              set_idis,
    input logic              vec_req
);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(mem_we || mem_re));

    // R10
    single_access_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R1
    page_range_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> (mem_addr[ADDR_W-1:BYTE_W] <= 1));

    // R2
    push_at_sp_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[BYTE_W-1:0] == sp));

    // R9
    push_dec_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (sp == $past(sp) - 8'd1));

    // R5
    pop_above_sp_chk: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> (mem_addr[BYTE_W-1:0] == sp + 8'd1));

    // R5
    pop_inc_chk: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> (sp == $past(sp) + 8'd1));

    // R4
    vec_follows_chk: assert property (@(posedge clk) disable iff (rst)
        set_idis |=> (vec_req && busy));

    // R6
    status_with_pc_chk: assert property (@(posedge clk) disable iff (rst)
        status_load |-> pc_load);

    // R7
    masked_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_valid && cmd == 3'd3 && irq_dis) |=> !busy);

endmodule

bind callstack_seq callstack_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd         (cmd),
    .irq_dis     (irq_dis),
    .mem_addr    (mem_addr),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .busy        (busy),
    .sp          (sp),
    .pc_load     (pc_load),
    .status_load (status_load),
    .set_idis    (set_idis),
    .vec_req     (vec_req)
);

// File: tb/callstack_seq_test.sv
`timescale 1ns/1ps
module callstack_seq_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [2:0]  cmd;
    logic        irq_dis;
    logic [15:0] pc_in;
    logic [7:0]  status_in;
    logic        page_sel;
    logic        sp_load;
    logic [7:0]  sp_load_val;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, mem_re, busy;
    logic [7:0]  sp;
    logic [15:0] pc_out;
    logic        pc_load;
    logic [7:0]  status_out;
    logic        status_load, set_idis, vec_req;

    logic [7:0]  mem [0:511];
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    callstack_seq uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .irq_dis(irq_dis),
        .pc_in(pc_in), .status_in(status_in), .page_sel(page_sel),
        .sp_load(sp_load), .sp_load_val(sp_load_val), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .busy(busy), .sp(sp), .pc_out(pc_out), .pc_load(pc_load),
        .status_out(status_out), .status_load(status_load),
        .set_idis(set_idis), .vec_req(vec_req)
    );

    assign mem_rdata = mem[mem_addr[8:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[8:0]] <= mem_wdata;

    // {cmd, sp0, page, pc, status, irq_dis}
    localparam int NV = 9;
    localparam logic [36:0] VEC [NV] = '{
        {3'd1, 8'h80, 1'b1, 16'h1234, 8'h00, 1'b0},
        {3'd1, 8'h01, 1'b0, 16'hABCD, 8'h00, 1'b0},
        {3'd2, 8'h40, 1'b1, 16'h5A6B, 8'h00, 1'b0},
        {3'd2, 8'hFF, 1'b0, 16'h0102, 8'h00, 1'b0},
        {3'd3, 8'h70, 1'b1, 16'h2468, 8'hC3, 1'b0},
        {3'd3, 8'h70, 1'b1, 16'h2468, 8'hC3, 1'b1},
        {3'd4, 8'h02, 1'b0, 16'h1357, 8'h81, 1'b1},
        {3'd5, 8'h30, 1'b1, 16'h9ABC, 8'hD5, 1'b0},
        {3'd3, 8'h10, 1'b0, 16'hFEED, 8'h10, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic int n_xfer(logic [2:0] c, logic idis);
        case (c)
            3'd1, 3'd2: return 2;
            3'd3:       return idis ? 0 : 3;
            3'd4, 3'd5: return 3;
            default:    return 0;
        endcase
    endfunction

    function automatic int n_busy(logic [2:0] c, logic idis);
        case (c)
            3'd1:    return 2;
            3'd2:    return 3;
            3'd3:    return idis ? 0 : 5;
            3'd4:    return 5;
            3'd5:    return 4;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] push_byte(logic [2:0] c, int k, logic [15:0] pc, logic [7:0] st);
        if (k == 0) return pc[15:8];
        if (k == 1) return pc[7:0];
        return (c == 3'd4) ? (st | 8'h10) : (st & 8'hEF);
    endfunction

    function automatic logic [7:0] pop_byte(logic [2:0] c, int k, logic [15:0] pc, logic [7:0] st);
        if (c == 3'd2) return (k == 0) ? pc[7:0] : pc[15:8];
        if (k == 0) return st;
        return (k == 1) ? pc[7:0] : pc[15:8];
    endfunction

    function automatic string tag_of(logic [2:0] c);
        case (c)
            3'd1: return "R2";
            3'd2: return "R5";
            3'd3: return "R3";
            3'd4: return "R8";
            default: return "R6";
        endcase
    endfunction

    task automatic run_vec(input logic [36:0] v);
        logic [2:0]  c;
        logic [7:0]  s0, st, lo, sp_exp;
        logic        pg, idis;
        logic [15:0] pc, pco;
        logic [7:0]  sto;
        logic [15:0] wa [4];
        logic [7:0]  wd [4];
        logic [15:0] ra [4];
        int n, nb, nw, nr, seti_at, vec_at;
        bit is_push, is_pop, pcl_seen, stl_seen;
        string tg;
        {c, s0, pg, pc, st, idis} = v;
        n = n_xfer(c, idis);
        is_push = (c == 3'd1 || c == 3'd3 || c == 3'd4) && n > 0;
        is_pop  = (c == 3'd2 || c == 3'd5);
        tg = tag_of(c);
        if (is_pop)
            for (int k = 0; k < n; k++) begin
                lo = s0 + 8'(k + 1);
                mem[{pg, lo}] = pop_byte(c, k, pc, st);
            end
        nb = 0; nw = 0; nr = 0; seti_at = -1; vec_at = -1;
        pcl_seen = 0; stl_seen = 0; pco = '0; sto = '0;
        @(negedge clk);
        sp_load = 1; sp_load_val = s0; cmd_valid = 1; cmd = c;
        pc_in = pc; status_in = st; page_sel = pg; irq_dis = idis;
        @(negedge clk);
        sp_load = 0; cmd_valid = 0; cmd = 3'd0;
        while (busy && nb < 12) begin
            if (mem_we && nw < 4) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; nw++; end
            if (mem_re && nr < 4) begin ra[nr] = mem_addr; nr++; end
            if (set_idis) seti_at = nb;
            if (vec_req) vec_at = nb;
            if (pc_load) begin pco = pc_out; pcl_seen = 1; end
            if (status_load) begin sto = status_out; stl_seen = 1; end
            nb++;
            @(negedge clk);
        end
        chk(nb == n_busy(c, idis), (c == 3'd3 && idis) ? "R7" : tg, "busy cycles", nb, n_busy(c, idis));
        if (is_push) begin
            chk(nw == n, tg, "write count", nw, n);
            for (int k = 0; k < n && k < nw; k++) begin
                lo = s0 - 8'(k);
                chk(wa[k] == {7'b0, pg, lo}, "R1", "push addr", wa[k], {7'b0, pg, lo});
                chk(wd[k] == push_byte(c, k, pc, st), tg, "push data", wd[k], push_byte(c, k, pc, st));
            end
            chk(nr == 0, tg, "no reads", nr, 0);
        end
        if (is_pop) begin
            chk(nr == n, tg, "read count", nr, n);
            for (int k = 0; k < n && k < nr; k++) begin
                lo = s0 + 8'(k + 1);
                chk(ra[k] == {7'b0, pg, lo}, "R1", "pop addr", ra[k], {7'b0, pg, lo});
            end
            chk(pcl_seen && pco == pc, tg, "restored pc", pco, pc);
            if (c == 3'd5)
                chk(stl_seen && sto == (st & 8'hEF), "R6", "restored status", sto, st & 8'hEF);
            else
                chk(!stl_seen, "R5", "no status load", stl_seen, 0);
        end
        if (c == 3'd3 && idis)
            chk(nw == 0 && nr == 0, "R7", "masked irq accesses", nw + nr, 0);
        if ((c == 3'd3 && !idis) || c == 3'd4) begin
            chk(seti_at == 3, "R4", "set_idis slot", seti_at, 3);
            chk(vec_at == 4, "R4", "vec_req slot", vec_at, 4);
        end else begin
            chk(seti_at == -1 && vec_at == -1, "R4", "no entry strobes", seti_at, -1);
        end
        sp_exp = is_pop ? s0 + 8'(n) : s0 - 8'(n);
        chk(sp == sp_exp, ((is_pop && s0 > sp_exp) || (!is_pop && s0 < sp_exp)) ? "R9" : tg,
            "final sp", sp, sp_exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int nrd, nb;
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        rst = 1; cmd_valid = 0; cmd = 0; irq_dis = 0; pc_in = 0; status_in = 0;
        page_sel = 0; sp_load = 0; sp_load_val = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!busy && !mem_we && !mem_re, "R10", "idle after reset", {busy, mem_we, mem_re}, 0);
        chk(!set_idis && !vec_req && !pc_load, "R10", "no strobes after reset",
            {set_idis, vec_req, pc_load}, 0);
        rst = 0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R10 command and pointer load during a call are ignored
        @(negedge clk);
        sp_load = 1; sp_load_val = 8'h50; cmd_valid = 1; cmd = 3'd1;
        pc_in = 16'h7777; page_sel = 1'b0; irq_dis = 1'b0;
        @(negedge clk);
        sp_load = 1; sp_load_val = 8'h00; cmd_valid = 1; cmd = 3'd2;
        nrd = 0; nb = 0;
        while (busy && nb < 12) begin
            if (mem_re) nrd++;
            nb++;
            @(negedge clk);
            sp_load = 0; cmd_valid = 0; cmd = 3'd0;
        end
        chk(nb == 2, "R10", "busy during ignored cmd", nb, 2);
        chk(nrd == 0, "R10", "no read from ignored cmd", nrd, 0);
        chk(sp == 8'h4E, "R10", "load ignored while busy", sp, 8'h4E);

        // R5 round trip: return without reloading the pointer
        cmd_valid = 1; cmd = 3'd2;
        @(negedge clk);
        cmd_valid = 0; cmd = 3'd0;
        nb = 0;
        while (busy && !pc_load && nb < 12) begin nb++; @(negedge clk); end
        chk(pc_load && pc_out == 16'h7777, "R5", "round trip pc", pc_out, 16'h7777);
        @(negedge clk);
        chk(sp == 8'h50 && !busy, "R5", "round trip sp", sp, 8'h50);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule